// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of 12-bit conversion results coming out of an analog-to-digital converter. Each result is compared against a lower and an upper limit, taken from one of several selectable limit pairs. A mode input decides what counts as a hit: a result that lies between the limits, or a result that lies beyond them.

A single hit is not enough to raise an alarm. Hits must arrive on a programmed number of back-to-back conversions. Any conversion that misses resets the running tally. When the tally completes, a sticky flag is set. The flag drives an interrupt line only while the interrupt enable is high. Software removes the flag by pulsing a write-one-to-clear input.

Top module: `adc_rng_cmp`

## Requirements
- R1: After reset, `flag_o` and `irq_o` are 0 and the hit tally is zero.
- R2: In inside mode (`outside_mode`=0), a result is a hit when lower <= result <= upper. Both limits are part of the window.
- R3: In outside mode (`outside_mode`=1), a result is a hit when result < lower or result > upper.
- R4: `pair_sel`=k selects limit pair k. Its upper limit is `thr_upper[k*12 +: 12]` and its lower limit is `thr_lower[k*12 +: 12]`.
- R5: The number of consecutive hits required is `need_cnt`+1, which gives a range of 1 to 8.
- R6: `flag_o` reads 1 in the cycle after the clock edge that samples the valid result completing the required run of hits.
- R7: A valid result that misses clears the tally to zero. Cycles with `res_valid`=0 leave the tally unchanged.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en` is 1.
- R9: `flag_o` stays 1 until `flag_clr` is sampled high. When it is cleared that way, it reads 0 in the next cycle.
- R10: If a run completes in the same cycle that `flag_clr` is high, the flag is set (set wins).
- R11: After a run completes, the tally restarts from zero, so a fresh full run is needed before another set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Conversion result |
| thr_upper | input | 48 | Upper limits, pair k at bits k*12 +: 12 |
| thr_lower | input | 48 | Lower limits, pair k at bits k*12 +: 12 |
| pair_sel | input | 2 | Limit pair select |
| outside_mode | input | 1 | 0 = hit inside window, 1 = hit outside window |
| irq_en | input | 1 | Interrupt enable |
| need_cnt | input | 3 | Consecutive hits required, minus one |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| flag_o | output | 1 | Sticky range flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag can be set by a completed run in the same cycle that a clear pulse arrives, and the two actions conflict. The bench provokes this directly: it drives the final hit of a run together with `flag_clr`, and it expects the flag to read 1 afterwards. The random phase also asserts clears often enough to collide with run completions many more times. In every cycle, the bench judges the flag against a reference model that applies set before clear.

// File: rtl/adc_rng_pkg.sv
package adc_rng_pkg;
    typedef enum logic {
        WIN_INSIDE  = 1'b0,
        WIN_OUTSIDE = 1'b1
    } win_mode_e;
endpackage

// File: rtl/adc_rng_window.sv
module adc_rng_window
    import adc_rng_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int NUM_PAIRS = 4,
    localparam int SEL_W    = $clog2(NUM_PAIRS)
) (
    input  logic [DATA_W-1:0]           data,
    input  logic [NUM_PAIRS*DATA_W-1:0] thr_upper,
    input  logic [NUM_PAIRS*DATA_W-1:0] thr_lower,
    input  logic [SEL_W-1:0]            pair_sel,
    input  logic                        outside_mode,
    output logic                        hit
);
    logic [DATA_W-1:0] up_arr [NUM_PAIRS];
    logic [DATA_W-1:0] lo_arr [NUM_PAIRS];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign up_arr[g] = thr_upper[g*DATA_W +: DATA_W];
        assign lo_arr[g] = thr_lower[g*DATA_W +: DATA_W];
    end

    logic [DATA_W-1:0] up_sel;
    logic [DATA_W-1:0] lo_sel;
    logic              in_win;
    win_mode_e         mode;

    always_comb begin
        up_sel = up_arr[pair_sel];
        lo_sel = lo_arr[pair_sel];
        in_win = (data >= lo_sel) && (data <= up_sel);
        mode   = win_mode_e'(outside_mode);
        hit    = (mode == WIN_OUTSIDE) ? !in_win : in_win;
    end
endmodule

// File: rtl/adc_rng_run.sv
module adc_rng_run #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             det,
    input  logic [CNT_W-1:0] need_cnt,
    output logic             done,
    output logic [CNT_W-1:0] run_q
);
    typedef struct packed {
        logic [CNT_W-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (valid) begin
            if (!det) begin
                st_d.run = '0;
            end else if (st_q.run >= need_cnt) begin
                done     = 1'b1;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_q = st_q.run;
endmodule

// File: rtl/adc_rng_cmp.sv
module adc_rng_cmp #(
    parameter int DATA_W    = 12,
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 3,
    localparam int SEL_W    = $clog2(NUM_PAIRS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        res_valid,
    input  logic [DATA_W-1:0]           res_data,
    input  logic [NUM_PAIRS*DATA_W-1:0] thr_upper,
    input  logic [NUM_PAIRS*DATA_W-1:0] thr_lower,
    input  logic [SEL_W-1:0]            pair_sel,
    input  logic                        outside_mode,
    input  logic                        irq_en,
    input  logic [CNT_W-1:0]            need_cnt,
    input  logic                        flag_clr,
    output logic                        flag_o,
    output logic                        irq_o
);
    typedef struct packed {
        logic flag;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             hit;
    logic             run_done;
    logic [CNT_W-1:0] run_q;

    adc_rng_window #(.DATA_W(DATA_W), .NUM_PAIRS(NUM_PAIRS)) u_win (
        .data        (res_data),
        .thr_upper   (thr_upper),
        .thr_lower   (thr_lower),
        .pair_sel    (pair_sel),
        .outside_mode(outside_mode),
        .hit         (hit)
    );

    adc_rng_run #(.CNT_W(CNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (res_valid),
        .det     (hit),
        .need_cnt(need_cnt),
        .done    (run_done),
        .run_q   (run_q)
    );

    always_comb begin
        st_d = st_q;
        if (run_done)      st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en;
endmodule

module adc_rng_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic             flag_clr,
    input logic             irq_en,
    input logic             flag_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] run_q
);
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !flag_clr |=> flag_o);                        // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !res_valid |=> !flag_o);                    // R9
    AST_SET_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o && !res_valid |=> !flag_o);                     // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);                                    // R8
    AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(run_q));                         // R7
endmodule

bind adc_rng_cmp adc_rng_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_valid(res_valid),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .flag_o   (flag_o),
    .irq_o    (irq_o),
    .run_q    (run_q)
);

// File: tb/adc_rng_cmp_test.sv
module adc_rng_cmp_test;
    localparam int SEED = 1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [47:0] thr_upper = '0;
    logic [47:0] thr_lower = '0;
    logic [1:0]  pair_sel = '0;
    logic        outside_mode = 1'b0;
    logic        irq_en = 1'b0;
    logic [2:0]  need_cnt = '0;
    logic        flag_clr = 1'b0;
    logic        flag_o, irq_o;

    int total = 0;
    int bad = 0;
    bit e_flag = 1'b0;
    int e_run = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    adc_rng_cmp uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .thr_upper(thr_upper), .thr_lower(thr_lower), .pair_sel(pair_sel),
        .outside_mode(outside_mode), .irq_en(irq_en), .need_cnt(need_cnt),
        .flag_clr(flag_clr), .flag_o(flag_o), .irq_o(irq_o)
    );

    function automatic bit is_hit(logic [11:0] d, logic [11:0] lo, logic [11:0] hi, bit outside);
        bit inw = (d >= lo) && (d <= hi);
        return outside ? !inw : inw;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(bit v, logic [11:0] d, bit clr, string tag);
        bit h, set;
        res_valid = v; res_data = d; flag_clr = clr;
        @(posedge clk);
        h = is_hit(d, thr_lower[pair_sel*12 +: 12], thr_upper[pair_sel*12 +: 12], outside_mode);
        set = 1'b0;
        if (v) begin
            if (!h) e_run = 0;
            else if (e_run >= int'(need_cnt)) begin set = 1'b1; e_run = 0; end
            else e_run++;
        end
        if (set) e_flag = 1'b1;
        else if (clr) e_flag = 1'b0;
        @(negedge clk);
        res_valid = 1'b0; flag_clr = 1'b0;
        chk(tag, flag_o, e_flag);
        chk({tag, " irq R8"}, irq_o, e_flag & irq_en);
    endtask

    task automatic wipe();
        cyc(0, 12'h0, 1, "R9 clear");
    endtask

    initial begin
        #2_000_000;
        if (!ended) begin
            ended = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(SEED));
        thr_lower[0 +: 12] = 12'h100; thr_upper[0 +: 12] = 12'h200;
        thr_lower[24 +: 12] = 12'h800; thr_upper[24 +: 12] = 12'h900;
        repeat (3) @(negedge clk);
        chk("R1 flag reset", flag_o, 1'b0);
        chk("R1 irq reset", irq_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        irq_en = 1'b1;

        // R2 inclusive inside window
        cyc(1, 12'h100, 0, "R2 low edge");   chk("R2 low edge hit", flag_o, 1'b1); wipe();
        cyc(1, 12'h200, 0, "R2 high edge");  chk("R2 high edge hit", flag_o, 1'b1); wipe();
        cyc(1, 12'h0FF, 0, "R2 below");      chk("R2 below miss", flag_o, 1'b0);
        cyc(1, 12'h201, 0, "R2 above");      chk("R2 above miss", flag_o, 1'b0);

        // R3 outside mode
        outside_mode = 1'b1;
        cyc(1, 12'h150, 0, "R3 inside");     chk("R3 inside miss", flag_o, 1'b0);
        cyc(1, 12'h0FF, 0, "R3 below");      chk("R3 below hit", flag_o, 1'b1); wipe();
        cyc(1, 12'h201, 0, "R3 above");      chk("R3 above hit", flag_o, 1'b1); wipe();
        outside_mode = 1'b0;

        // R4 pair selection
        pair_sel = 2'd2;
        cyc(1, 12'h850, 0, "R4 pair2");      chk("R4 pair2 hit", flag_o, 1'b1); wipe();
        pair_sel = 2'd0;
        cyc(1, 12'h850, 0, "R4 pair0");      chk("R4 pair0 miss", flag_o, 1'b0);

        // R5 R6 run length of three
        need_cnt = 3'd2;
        cyc(1, 12'h150, 0, "R5 h1");
        cyc(1, 12'h150, 0, "R5 h2");         chk("R5 two hits not enough", flag_o, 1'b0);
        cyc(1, 12'h150, 0, "R6 h3");         chk("R6 third hit sets", flag_o, 1'b1); wipe();
        // R7 miss resets, idle holds
        cyc(1, 12'h150, 0, "R7 a"); cyc(1, 12'h150, 0, "R7 b");
        cyc(1, 12'h050, 0, "R7 miss");
        cyc(1, 12'h150, 0, "R7 c"); cyc(1, 12'h150, 0, "R7 d");
        chk("R7 miss restarted run", flag_o, 1'b0);
        cyc(0, 12'h050, 0, "R7 idle"); cyc(0, 12'h050, 0, "R7 idle");
        chk("R7 idle keeps tally", flag_o, 1'b0);
        cyc(1, 12'h150, 0, "R7 e");          chk("R7 run completes", flag_o, 1'b1);

        // R8 irq gating and R9 stickiness
        irq_en = 1'b0; #1;
        chk("R8 masked irq", irq_o, 1'b0);
        irq_en = 1'b1; #1;
        chk("R8 enabled irq", irq_o, 1'b1);
        repeat (4) cyc(0, 12'h0, 0, "R9 sticky");
        chk("R9 still set", flag_o, 1'b1);
        wipe();                              chk("R9 cleared", flag_o, 1'b0);

        // R10 set wins over clear
        need_cnt = 3'd0;
        cyc(1, 12'h150, 0, "R10 pre");
        cyc(1, 12'h150, 1, "R10 collide");   chk("R10 set beats clear", flag_o, 1'b1); wipe();

        // R11 restart after completion
        need_cnt = 3'd1;
        cyc(1, 12'h150, 0, "R11 a"); cyc(1, 12'h150, 0, "R11 b");
        chk("R11 first run", flag_o, 1'b1); wipe();
        cyc(1, 12'h150, 0, "R11 c");         chk("R11 needs fresh run", flag_o, 1'b0);
        cyc(1, 12'h150, 0, "R11 d");         chk("R11 second run", flag_o, 1'b1); wipe();

        // random phase
        for (int p = 0; p < 4; p++) begin
            thr_lower[p*12 +: 12] = 12'($urandom_range(0, 2000));
            thr_upper[p*12 +: 12] = 12'($urandom_range(1500, 4095));
        end
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) begin
                pair_sel = 2'($urandom);
                outside_mode = 1'($urandom);
                need_cnt = 3'($urandom);
                irq_en = 1'($urandom);
            end
            cyc(1'($urandom_range(0, 3) != 0), 12'($urandom),
                $urandom_range(0, 7) == 0, "R6 R10 random");
        end

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule